// File: doc/BRIEF.md
# Front-End Mode Decoder and Serial Configuration Chain

This block sits between three control pins of a multi-channel front-end and the logic they steer. Two level pins, an enable and a write-enable, are synchronised to the pin clock. They select one of three operating modes: acquisition, readout or configuration. Short pulses on the same pins request either a global reset or an acquisition reset. The block tells the downstream logic which function the clock serves in each mode through a one-hot set of tick enables. In acquisition mode it hands the serial data pin on as the test-pulser clock.

In configuration mode each clock shifts one bit from the data pin into a chain made of one global register and one register per channel. The chain's far end leaves on a data output that changes on the falling clock edge, so several blocks can be daisy-chained. The parallel register contents are copied from the chain only when a configuration session ends after at least a full chain length of bits. Downstream logic therefore never sees a half-written value.

Top module: `fe_mode_cfg`

## Requirements
- R1: After reset (rst_n low) mode_o is 2'b00 (readout), rd_tick is 1, cnt_tick, wr_tick, glb_rst, acq_rst, pulser_clk and dout_pin are 0, and glob_cfg and chan_cfg are all zero.
- R2: mode_o is 2'b01 (acquisition) when the enable pin is high and the write-enable pin is low. It is 2'b00 (readout) when both are low, and 2'b10 (configuration) whenever write-enable is high. A pin change shows on mode_o after the second rising clock edge and not after the first.
- R3: Exactly one of cnt_tick (acquisition), rd_tick (readout) and wr_tick (configuration) is high, and it is the one that matches mode_o.
- R4: pulser_clk follows din_pin while in acquisition mode and is 0 in every other mode.
- R5: In configuration mode with enable low, each rising edge shifts the synchronised din_pin into the chain. The chain is CHAIN = 36 + 10*N_CH bits, and the oldest of the last CHAIN bits sent ends at its top. When write-enable drops after at least CHAIN shifts, glob_cfg takes the first 36 of those CHAIN bits, first bit at glob_cfg[35]. Channel i, bits chan_cfg[10*i+9:10*i], takes the 10 bits that follow the global bits and the bits of channels below i, first bit at the top.
- R6: glob_cfg and chan_cfg do not change while mode_o is configuration, except on a global reset.
- R7: dout_pin presents the top bit of the chain and updates on the falling clock edge. During a session the previous chain contents leave in the order they were sent, followed by the new bits.
- R8: A write-enable high interval with fewer than CHAIN shifts gives one single-cycle acq_rst pulse when write-enable drops, and leaves glob_cfg and chan_cfg unchanged.
- R9: A session of CHAIN or more shifts produces no acq_rst pulse.
- R10: A falling enable (synchronised) while write-enable is high gives one single-cycle glb_rst pulse. It clears glob_cfg, chan_cfg and the chain, and the remainder of that session neither loads the registers nor produces an acq_rst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pin clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable control pin |
| wren_pin | input | 1 | Write-enable control pin |
| din_pin | input | 1 | Serial configuration data / pulser clock pin |
| dout_pin | output | 1 | Serial chain output, updated on falling clock edge |
| mode_o | output | 2 | 00 readout, 01 acquisition, 10 configuration |
| cnt_tick | output | 1 | Clock serves the timing counter |
| rd_tick | output | 1 | Clock serves readout |
| wr_tick | output | 1 | Clock serves register write-in |
| pulser_clk | output | 1 | Test-pulser clock (din_pin in acquisition) |
| glb_rst | output | 1 | Single-cycle global reset request |
| acq_rst | output | 1 | Single-cycle acquisition reset request |
| glob_cfg | output | 36 | Parallel global register |
| chan_cfg | output | 10*N_CH | Parallel per-channel registers, channel i at [10*i+9:10*i] |

## Verification
The bench sweeps all four pin combinations and checks the mode code one edge after a pin change and again two edges after it. A design with one fewer synchroniser stage would show the new mode early, and one that gated the pulser on the raw pin would leak din in readout. It runs exact, over-long and short sessions and predicts every bit on dout_pin, so an output that changes on the rising edge shows up as a one-bit slip. The same runs catch a wrong channel mapping, a load of partial data and an acquisition reset raised after a full session. A global reset in the middle of a session must clear the chain as well as the registers: a later session's dout stream must read as zeros, and no load or acquisition reset may follow.

// File: rtl/fe_cfg_pkg.sv
`timescale 1ns/100ps
package fe_cfg_pkg;

  localparam int GLB_W = 36;
  localparam int CH_W  = 10;

  typedef enum logic [1:0] {
    MD_READ = 2'b00,
    MD_ACQ  = 2'b01,
    MD_CFG  = 2'b10
  } mode_e;

  function automatic mode_e decode_mode(input logic en, input logic wr);
    if (wr)      return MD_CFG;
    else if (en) return MD_ACQ;
    else         return MD_READ;
  endfunction

  function automatic int chain_len(input int n_ch);
    return GLB_W + CH_W * n_ch;
  endfunction

  // top bit index of channel i inside the chain
  function automatic int chan_hi(input int i, input int n_ch);
    return CH_W * (n_ch - i) - 1;
  endfunction

endpackage

// File: rtl/fe_pin_sync.sv
`timescale 1ns/100ps
module fe_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else         stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fe_mode_dec.sv
`timescale 1ns/100ps
module fe_mode_dec
  import fe_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_s,
  input  logic  wr_s,
  output mode_e mode,
  output logic  cnt_en,
  output logic  rd_en,
  output logic  wr_en,
  output logic  shift_en,
  output logic  wr_fall,
  output logic  grst_evt
);
  logic en_d, wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d <= 1'b0;
      wr_d <= 1'b0;
    end else begin
      en_d <= en_s;
      wr_d <= wr_s;
    end
  end

  assign mode     = decode_mode(en_s, wr_s);
  assign cnt_en   = (mode == MD_ACQ);
  assign rd_en    = (mode == MD_READ);
  assign wr_en    = (mode == MD_CFG);
  assign shift_en = wr_en && !en_s;
  assign wr_fall  = wr_d && !wr_s;
  assign grst_evt = en_d && !en_s && wr_s;
endmodule

// File: rtl/fe_shift_chain.sv
`timescale 1ns/100ps
module fe_shift_chain #(
  parameter int LEN = 76
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       shift,
  input  logic                       cnt_clr,
  input  logic                       din,
  output logic [LEN-1:0]             chain,
  output logic [$clog2(LEN+1)-1:0]   cnt,
  output logic                       dout
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LIM = CW'(LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      cnt   <= '0;
    end else if (clr) begin
      chain <= '0;
      cnt   <= '0;
    end else if (shift) begin
      chain <= {chain[LEN-2:0], din};
      if (cnt != LIM) cnt <= cnt + 1'b1;
    end else if (cnt_clr) begin
      cnt <= '0;
    end
  end

  // half-period delayed serial output
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= chain[LEN-1];
  end
endmodule

// File: rtl/fe_mode_cfg.sv
`timescale 1ns/100ps
module fe_mode_cfg
  import fe_cfg_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_pin,
  input  logic                 wren_pin,
  input  logic                 din_pin,
  output logic                 dout_pin,
  output logic [1:0]           mode_o,
  output logic                 cnt_tick,
  output logic                 rd_tick,
  output logic                 wr_tick,
  output logic                 pulser_clk,
  output logic                 glb_rst,
  output logic                 acq_rst,
  output logic [GLB_W-1:0]     glob_cfg,
  output logic [N_CH*CH_W-1:0] chan_cfg
);
  localparam int CHAIN = chain_len(N_CH);
  localparam int CNT_W = $clog2(CHAIN + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CHAIN);

  logic [2:0] pin_s;
  logic       en_s, wr_s, din_s;
  mode_e      mode;
  logic       shift_en, wr_fall, grst_evt;
  logic [CHAIN-1:0] chain;
  logic [CNT_W-1:0] shift_cnt;
  logic       abort_q;
  logic       session_full, load_evt;
  logic [CHAIN-1:0] shadow;

  fe_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({en_pin, wren_pin, din_pin}),
    .q   (pin_s)
  );
  assign {en_s, wr_s, din_s} = pin_s;

  fe_mode_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_s     (en_s),
    .wr_s     (wr_s),
    .mode     (mode),
    .cnt_en   (cnt_tick),
    .rd_en    (rd_tick),
    .wr_en    (wr_tick),
    .shift_en (shift_en),
    .wr_fall  (wr_fall),
    .grst_evt (grst_evt)
  );

  fe_shift_chain #(.LEN(CHAIN)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (grst_evt),
    .shift   (shift_en),
    .cnt_clr (wr_fall),
    .din     (din_s),
    .chain   (chain),
    .cnt     (shift_cnt),
    .dout    (dout_pin)
  );

  // session bookkeeping: a global reset poisons the rest of the session
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        abort_q <= 1'b0;
    else if (grst_evt) abort_q <= 1'b1;
    else if (wr_fall)  abort_q <= 1'b0;
  end

  assign session_full = (shift_cnt == FULL);
  assign load_evt     = wr_fall && !abort_q && session_full;
  assign acq_rst      = wr_fall && !abort_q && !session_full;
  assign glb_rst      = grst_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shadow <= '0;
    else if (grst_evt) shadow <= '0;
    else if (load_evt) shadow <= chain;
  end

  assign mode_o     = mode;
  assign pulser_clk = din_pin && cnt_tick;
  assign glob_cfg   = shadow[CHAIN-1 -: GLB_W];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign chan_cfg[i*CH_W +: CH_W] = shadow[chan_hi(i, N_CH) -: CH_W];
  end
endmodule

// File: rtl/fe_mode_cfg_chk.sv
`timescale 1ns/100ps
module fe_mode_cfg_chk
  import fe_cfg_pkg::*;
#(
  parameter int N_CH = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode_o,
  input logic                 cnt_tick,
  input logic                 rd_tick,
  input logic                 wr_tick,
  input logic                 pulser_clk,
  input logic                 glb_rst,
  input logic                 acq_rst,
  input logic [GLB_W-1:0]     glob_cfg,
  input logic [N_CH*CH_W-1:0] chan_cfg
);
  AST_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({cnt_tick, rd_tick, wr_tick})); // R3
  AST_CFG_TICK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tick |-> (mode_o == 2'b10)); // R3
  AST_PULSER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |-> !pulser_clk); // R4
  AST_HOLD_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tick && !glb_rst) |=> ($stable(glob_cfg) && $stable(chan_cfg))); // R6
  AST_ACQRST_OUTSIDE_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    acq_rst |-> !wr_tick); // R8
  AST_ACQRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acq_rst |=> !acq_rst); // R8
  AST_GRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    glb_rst |=> !glb_rst); // R10
  AST_GRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    glb_rst |=> (glob_cfg == '0 && chan_cfg == '0)); // R10
  AST_RST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(glb_rst && acq_rst)); // R10
endmodule

bind fe_mode_cfg fe_mode_cfg_chk #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_o     (mode_o),
  .cnt_tick   (cnt_tick),
  .rd_tick    (rd_tick),
  .wr_tick    (wr_tick),
  .pulser_clk (pulser_clk),
  .glb_rst    (glb_rst),
  .acq_rst    (acq_rst),
  .glob_cfg   (glob_cfg),
  .chan_cfg   (chan_cfg)
);

// File: tb/test_fe_mode_cfg.sv
`timescale 1ns/100ps
module test_fe_mode_cfg;
  localparam int NCH   = 4;
  localparam int GW    = 36;
  localparam int CWD   = 10;
  localparam int CHAIN = GW + CWD * NCH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, wren = 1'b0, din = 1'b0;
  logic dout;
  logic [1:0] mode;
  logic cnt_t, rd_t, wr_t, pclk, grst, arst;
  logic [GW-1:0] glob;
  logic [NCH*CWD-1:0] chan;

  int n_chk = 0, n_fail = 0;
  int n_acq = 0, n_grs = 0;
  bit done = 0;

  logic [CHAIN-1:0] mchain = '0;
  logic [CHAIN-1:0] mshadow = '0;

  always #2.5 clk = ~clk;

  fe_mode_cfg #(.N_CH(NCH)) i_fe_mode_cfg (
    .clk (clk), .rst_n (rst_n), .en_pin (en), .wren_pin (wren),
    .din_pin (din), .dout_pin (dout), .mode_o (mode),
    .cnt_tick (cnt_t), .rd_tick (rd_t), .wr_tick (wr_t),
    .pulser_clk (pclk), .glb_rst (grst), .acq_rst (arst),
    .glob_cfg (glob), .chan_cfg (chan)
  );

  always @(negedge clk) begin
    if (rst_n && arst) n_acq++;
    if (rst_n && grst) n_grs++;
  end

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic pat(input int seed, input int k);
    return logic'((((k * 7) + (seed * 13) + ((k >> 1) * k)) % 5) < 2);
  endfunction

  function automatic logic [GW-1:0] exp_glob(input logic [CHAIN-1:0] s);
    return s[CHAIN-1 -: GW];
  endfunction

  function automatic logic [NCH*CWD-1:0] exp_chan(input logic [CHAIN-1:0] s);
    logic [NCH*CWD-1:0] r;
    for (int i = 0; i < NCH; i++)
      r[i*CWD +: CWD] = s[CHAIN-GW-1-i*CWD -: CWD];
    return r;
  endfunction

  // expected one-hot of ticks per mode code
  task automatic check_mode(input string tag, input logic [1:0] m);
    check({tag, " R2 mode"}, 80'(mode), 80'(m));
    check({tag, " R3 ticks"}, 80'({cnt_t, rd_t, wr_t}),
          80'({m == 2'b01, m == 2'b00, m == 2'b10}));
  endtask

  task automatic set_pins(input logic e, input logic w, input logic [1:0] old_m, input logic [1:0] new_m);
    @(negedge clk); en = e; wren = w; din = 1'b0;
    @(negedge clk); #1;
    check("latency-1", 80'(mode), 80'(old_m)); // R2: not yet after first edge
    @(negedge clk); #1;
    check_mode("latency-2", new_m);
  endtask

  task automatic session(input int seed, input int len);
    logic [CHAIN-1:0] old;
    logic dout_bad, hold_bad, e;
    int c;
    old = mchain; dout_bad = 0; hold_bad = 0;
    n_acq = 0; n_grs = 0;
    for (int j = 0; j < len + 2; j++) begin
      @(negedge clk);
      if (j < len) begin wren = 1'b1; din = pat(seed, j); end
      else begin wren = 1'b0; din = 1'b0; end
      #1;
      c = j - 2;
      if (c < 0) c = 0;
      e = (c < CHAIN) ? old[CHAIN-1-c] : pat(seed, c - CHAIN);
      if (dout !== e) dout_bad = 1;
      if (glob !== exp_glob(mshadow) || chan !== exp_chan(mshadow)) hold_bad = 1;
    end
    repeat (5) @(negedge clk);
    #1;
    for (int k = 0; k < len; k++) mchain = {mchain[CHAIN-2:0], pat(seed, k)};
    if (len >= CHAIN) mshadow = mchain;
    check("R7 dout stream", 80'(dout_bad), 80'(0));
    check("R6 outputs held during cfg", 80'(hold_bad), 80'(0));
    check("R5 glob_cfg", 80'(glob), 80'(exp_glob(mshadow)));
    check("R5 chan_cfg", 80'(chan), 80'(exp_chan(mshadow)));
    if (len >= CHAIN) check("R9 no acq_rst on full session", 80'(n_acq), 80'(0));
    else              check("R8 one acq_rst on short session", 80'(n_acq), 80'(1));
    check("R8 no glb_rst", 80'(n_grs), 80'(0));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 mode", 80'(mode), 80'(0));
    check("R1 ticks", 80'({cnt_t, rd_t, wr_t}), 80'(3'b010));
    check("R1 resets/pulser/dout", 80'({grst, arst, pclk, dout}), 80'(0));
    check("R1 glob", 80'(glob), 80'(0));
    check("R1 chan", 80'(chan), 80'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // mode sweep
    set_pins(1'b0, 1'b0, 2'b00, 2'b00);
    set_pins(1'b1, 1'b0, 2'b00, 2'b01);
    @(negedge clk); din = 1'b1; #1;
    check("R4 pulser follows din high", 80'(pclk), 80'(1));
    @(negedge clk); din = 1'b0; #1;
    check("R4 pulser follows din low", 80'(pclk), 80'(0));
    set_pins(1'b0, 1'b0, 2'b01, 2'b00);
    @(negedge clk); din = 1'b1; #1;
    check("R4 pulser off in readout", 80'(pclk), 80'(0));
    @(negedge clk); din = 1'b0;
    set_pins(1'b0, 1'b1, 2'b00, 2'b10);
    set_pins(1'b1, 1'b1, 2'b10, 2'b10);
    set_pins(1'b0, 1'b0, 2'b10, 2'b00);
    repeat (4) @(negedge clk);
    check("R8 registers untouched by sweep", 80'({glob, chan} == '0), 80'(1));

    // configuration sessions
    session(1, CHAIN);
    session(2, CHAIN);
    session(3, CHAIN + 5);
    session(4, 3);
    session(5, CHAIN);

    // global reset in the middle of a session
    n_acq = 0; n_grs = 0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk); wren = 1'b1; din = pat(9, j);
    end
    @(negedge clk); din = 1'b0; en = 1'b1;
    repeat (2) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    wren = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    check("R10 single glb_rst", 80'(n_grs), 80'(1));
    check("R10 no acq_rst after abort", 80'(n_acq), 80'(0));
    check("R10 glob cleared", 80'(glob), 80'(0));
    check("R10 chan cleared", 80'(chan), 80'(0));
    mchain = '0; mshadow = '0;
    session(6, CHAIN); // dout stream must show a cleared chain (R10)

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule